// File: doc/BRIEF.md
# Configuration Access Filter and Completion Collector

This block stands next to the configuration request builder of a PCIe root port. For each configuration access it decides whether the access may go out on the link at all. Accesses that are not allowed are answered locally. When an access is allowed, the block raises a one-cycle launch strobe for the builder. It then waits for the completion that comes back, takes the data word from the beat that carries the end-of-packet marker, and returns the requested byte, halfword or dword. If no completion ends within a bounded number of polling intervals, it gives up with a timeout result.

Every access ends with a single-cycle `done` pulse and a 2-bit result code:

| Code | Result |
|------|--------|
| 0 | success |
| 1 | device not found |
| 2 | bad register |
| 3 | timeout |

The access fields are the bus number, devfn, byte offset, access size and the read/write flag. The block also takes the current root bus number, the primary bus number of the target bus, and the low four bits of the link training-state field. The polling interval length and the number of intervals allowed are parameters.

Top module: `cfg_cpl_filter`

## Requirements
- R1: A request on the root bus with devfn 0 and offset 0x010 ends one cycle later with `done`, result 2 (bad register) and `rdata` 0, and `launch` stays low.
- R2: A request to a bus other than the root bus is treated as follows. If `link_lts` is 0, the request ends one cycle later with result 1 (not found) and without `launch`. If any bit of `link_lts` is set, the link counts as up.
- R3: The device number is `req_devfn[7:3]`. A nonzero device number ends with result 1 and no `launch` when the target bus is the root bus. It does the same when `prim_bus` equals the root bus.
- R4: A rejected read returns `rdata` 0xFFFFFFFF with result 1. A rejected write returns `rdata` 0.
- R5: For an accepted request, `launch` pulses one cycle after the request and `busy` goes high. A completion beat that has `cpl_eop` set while `busy` is high ends the access one cycle later with result 0 and `busy` low. Beats without the end marker do not end the access.
- R6: An access that receives no end beat ends with result 3 (timeout) after exactly POLL_CYCLES*MAX_POLLS cycles of waiting. The wait count starts over for each access.
- R7: A 1-byte read (`req_size` 0) returns `cpl_data` shifted right by 8 times offset[1:0], masked to 8 bits.
- R8: A 2-byte read (`req_size` 1) returns `cpl_data` shifted right by 16 times offset[1], masked to 16 bits.
- R9: A 4-byte read (`req_size` 2 or 3) returns `cpl_data` unchanged.
- R10: An accepted write also waits for an end beat and can time out. It reports result 0 with `rdata` 0 when the end beat arrives.
- R11: `done` is a one-cycle pulse. Completion beats that arrive while idle are dropped. Requests that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe, taken only while idle |
| req_write | input | 1 | 1 = configuration write |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Device (bits 7:3) and function |
| req_offset | input | 12 | Register byte offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 dword |
| root_bus | input | 8 | Current root bus number |
| prim_bus | input | 8 | Primary bus number of the target bus |
| link_lts | input | 4 | Low four bits of the link training-state field |
| cpl_valid | input | 1 | Completion beat present |
| cpl_eop | input | 1 | Beat is the last of its packet |
| cpl_data | input | 32 | First word of the beat |
| launch | output | 1 | Pulse: send the request packet |
| busy | output | 1 | Waiting for a completion |
| done | output | 1 | Pulse: access finished |
| result | output | 2 | Result code, valid with `done` |
| rdata | output | 32 | Read data, valid with `done` |

## Verification
The bench checks the hidden register at offset 0x010 and also at the neighbouring offset 0x014. A filter that decodes too loosely would then hide an ordinary register, and one that decodes too tightly would launch a packet. Link gating is exercised with the link field at 0 and with only its top bit set. A design that tests only bit 0 would report a live link as absent. The timeout is timed to the exact cycle on two accesses in a row, after one that ended early. A counter that is not cleared would expire early on the second access. Byte and halfword reads at offsets 3 and 2 catch a wrong shift, and idle beats and requests made while busy catch state that is not held.

// File: rtl/cfg_cpl_pkg.sv
// Package: shared result codes and size encodings for the configuration
// access filter. Assumes nothing beyond IEEE 1800-2017.
package cfg_cpl_pkg;
    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_NOTFOUND = 2'd1,
        RES_BADREG   = 2'd2,
        RES_TIMEOUT  = 2'd3
    } cfg_result_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    localparam logic [31:0] RD_ALL_ONES = 32'hFFFF_FFFF;
endpackage

// File: rtl/cfg_access_gate.sv
// Module: decides whether a configuration access may go out on the link.
// Purely combinational. Assumes the hidden register is the first base
// address register of the root port function (root bus, devfn 0, offset 0x10).
module cfg_access_gate #(
    parameter int BUS_W   = 8,
    parameter int DEVFN_W = 8,
    parameter int OFF_W   = 12,
    parameter int LTS_W   = 4,
    parameter int HIDE_OFFSET = 16
) (
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [OFF_W-1:0]   offset,
    input  logic [BUS_W-1:0]   root_bus,
    input  logic [BUS_W-1:0]   prim_bus,
    input  logic [LTS_W-1:0]   link_lts,
    output logic               hide_reg,
    output logic               no_device
);
    localparam int DEV_LSB = 3;

    logic on_root;
    logic link_up;
    logic dev_nonzero;

    // Classify the target and the link, then apply the topology rules.
    always_comb begin
        on_root     = (bus == root_bus);
        link_up     = |link_lts;
        dev_nonzero = |devfn[DEVFN_W-1:DEV_LSB];
        hide_reg    = on_root && (devfn == '0) && (offset == OFF_W'(HIDE_OFFSET));
        no_device   = (!on_root && !link_up) ||
                      (on_root && dev_nonzero) ||
                      ((prim_bus == root_bus) && dev_nonzero);
    end
endmodule

// File: rtl/cfg_poll_timer.sv
// Module: counts polling intervals while an access waits for its completion.
// Assumes POLL_CYCLES >= 1 and MAX_POLLS >= 1. It is cleared whenever the
// owner is not waiting, so every access starts from zero.
module cfg_poll_timer #(
    parameter int POLL_CYCLES = 250,
    parameter int MAX_POLLS   = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int PRE_W = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(POLL_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_POLLS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] polls_q;
    logic             tick;

    // An interval ends on the last prescaler cycle.
    always_comb begin
        tick    = run && (pre_q == PRE_LAST);
        expired = tick && (polls_q == CNT_LAST);
    end

    // Advance the prescaler and interval count while running, else clear them.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q   <= '0;
            polls_q <= '0;
        end else if (tick) begin
            pre_q   <= '0;
            polls_q <= polls_q + 1'b1;
        end else begin
            pre_q   <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_lane_extract.sv
// Module: selects the requested byte or halfword from a completion dword.
// Combinational. Assumes the offset is the byte address of the access.
module cfg_lane_extract
    import cfg_cpl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] dword,
    input  logic [1:0]        size,
    input  logic [1:0]        off_lo,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] by_byte;
    logic [DATA_W-1:0] by_half;

    // Shift the addressed lane down and mask it to the access width.
    always_comb begin
        by_byte = (dword >> (8 * off_lo)) & DATA_W'(8'hFF);
        by_half = (dword >> (16 * off_lo[1])) & DATA_W'(16'hFFFF);
        case (size)
            SZ_BYTE: value = by_byte;
            SZ_HALF: value = by_half;
            default: value = dword;
        endcase
    end
endmodule

// File: rtl/cfg_cpl_filter.sv
// Module: top of the configuration access filter and completion collector.
// Takes one access at a time. It rejects the access locally, or it launches
// the access and waits for an end-of-packet beat or for a timeout.
// Assumes the builder sends the packet in the cycle that launch is high.
module cfg_cpl_filter
    import cfg_cpl_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int DEVFN_W     = 8,
    parameter int OFF_W       = 12,
    parameter int LTS_W       = 4,
    parameter int DATA_W      = 32,
    parameter int POLL_CYCLES = 250,
    parameter int MAX_POLLS   = 500
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [OFF_W-1:0]   req_offset,
    input  logic [1:0]         req_size,
    input  logic [BUS_W-1:0]   root_bus,
    input  logic [BUS_W-1:0]   prim_bus,
    input  logic [LTS_W-1:0]   link_lts,
    input  logic               cpl_valid,
    input  logic               cpl_eop,
    input  logic [DATA_W-1:0]  cpl_data,
    output logic               launch,
    output logic               busy,
    output logic               done,
    output logic [1:0]         result,
    output logic [DATA_W-1:0]  rdata
);
    typedef enum logic { ST_IDLE = 1'b0, ST_WAIT = 1'b1 } state_e;

    state_e            state_q;
    logic              launch_q;
    logic              done_q;
    cfg_result_e       res_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_q;
    logic [1:0]        size_q;
    logic [1:0]        off_q;

    logic              hide_reg;
    logic              no_device;
    logic              expired;
    logic [DATA_W-1:0] lane_val;
    logic              end_beat;

    cfg_access_gate #(
        .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFF_W(OFF_W), .LTS_W(LTS_W),
        .HIDE_OFFSET(16)
    ) u_gate (
        .bus(req_bus), .devfn(req_devfn), .offset(req_offset),
        .root_bus(root_bus), .prim_bus(prim_bus), .link_lts(link_lts),
        .hide_reg(hide_reg), .no_device(no_device)
    );

    cfg_poll_timer #(
        .POLL_CYCLES(POLL_CYCLES), .MAX_POLLS(MAX_POLLS)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_WAIT), .expired(expired)
    );

    cfg_lane_extract #(
        .DATA_W(DATA_W)
    ) u_lane (
        .dword(cpl_data), .size(size_q), .off_lo(off_q), .value(lane_val)
    );

    // A beat closes the pending access only when it carries the end marker.
    always_comb end_beat = (state_q == ST_WAIT) && cpl_valid && cpl_eop;

    // Accept requests, answer rejections and close accesses on end beat or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            launch_q <= 1'b0;
            done_q   <= 1'b0;
            res_q    <= RES_OK;
            rdata_q  <= '0;
            wr_q     <= 1'b0;
            size_q   <= '0;
            off_q    <= '0;
        end else begin
            launch_q <= 1'b0;
            done_q   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q   <= req_write;
                        size_q <= req_size;
                        off_q  <= req_offset[1:0];
                        if (hide_reg) begin
                            done_q  <= 1'b1;
                            res_q   <= RES_BADREG;
                            rdata_q <= '0;
                        end else if (no_device) begin
                            done_q  <= 1'b1;
                            res_q   <= RES_NOTFOUND;
                            rdata_q <= req_write ? '0 : RD_ALL_ONES;
                        end else begin
                            launch_q <= 1'b1;
                            state_q  <= ST_WAIT;
                        end
                    end
                end
                default: begin
                    if (end_beat) begin
                        done_q  <= 1'b1;
                        res_q   <= RES_OK;
                        rdata_q <= wr_q ? '0 : lane_val;
                        state_q <= ST_IDLE;
                    end else if (expired) begin
                        done_q  <= 1'b1;
                        res_q   <= RES_TIMEOUT;
                        rdata_q <= '0;
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Drive the ports from the registered state.
    always_comb begin
        launch = launch_q;
        busy   = (state_q == ST_WAIT);
        done   = done_q;
        result = res_q;
        rdata  = rdata_q;
    end
endmodule

// File: rtl/cfg_cpl_filter_chk.sv
// Checker: temporal properties of cfg_cpl_filter, bound to every instance.
module cfg_cpl_filter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_bus,
    input logic [7:0]  req_devfn,
    input logic [11:0] req_offset,
    input logic [7:0]  root_bus,
    input logic [3:0]  link_lts,
    input logic        cpl_valid,
    input logic        cpl_eop,
    input logic        launch,
    input logic        busy,
    input logic        done,
    input logic [1:0]  result,
    input logic [31:0] rdata
);
    p_hidden_bar_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_bus == root_bus && req_devfn == 8'd0 &&
         req_offset == 12'h010)
        |=> (done && result == 2'd2 && !launch));

    p_link_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_bus != root_bus && link_lts == 4'd0)
        |=> (done && result == 2'd1 && !launch));

    p_reject_read_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_write && req_bus != root_bus && link_lts == 4'd0)
        |=> (rdata == 32'hFFFF_FFFF));

    p_launch_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> ($past(req_valid) && !$past(busy) && busy));

    p_end_beat_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpl_valid && cpl_eop) |=> (done && result == 2'd0 && !busy));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_idle_beat_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> !done);
endmodule

bind cfg_cpl_filter cfg_cpl_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
    .root_bus(root_bus), .link_lts(link_lts), .cpl_valid(cpl_valid),
    .cpl_eop(cpl_eop), .launch(launch), .busy(busy), .done(done),
    .result(result), .rdata(rdata)
);

// File: tb/sim_cfg_cpl_filter.sv
module sim_cfg_cpl_filter;
    localparam int CLK_PERIOD = 10;
    localparam int POLL = 4;
    localparam int MAXP = 5;
    localparam int TMO  = POLL * MAXP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_bus = '0, req_devfn = '0, root_bus = 8'd0, prim_bus = 8'd0;
    logic [11:0] req_offset = '0;
    logic [1:0]  req_size = '0;
    logic [3:0]  link_lts = 4'h0;
    logic        cpl_valid = 1'b0, cpl_eop = 1'b0;
    logic [31:0] cpl_data = '0;
    logic        launch, busy, done;
    logic [1:0]  result;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_bad = 0;

    cfg_cpl_filter #(.POLL_CYCLES(POLL), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
        .req_size(req_size), .root_bus(root_bus), .prim_bus(prim_bus),
        .link_lts(link_lts), .cpl_valid(cpl_valid), .cpl_eop(cpl_eop),
        .cpl_data(cpl_data), .launch(launch), .busy(busy), .done(done),
        .result(result), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one request for a single cycle; returns after outputs update.
    task automatic issue(input logic wr, input logic [7:0] bus, input logic [7:0] devfn,
                         input logic [11:0] off, input logic [1:0] sz);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bus = bus; req_devfn = devfn;
        req_offset = off; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Present one completion beat; returns after outputs update.
    task automatic beat(input logic eop, input logic [31:0] d);
        cpl_valid = 1'b1; cpl_eop = eop; cpl_data = d;
        @(negedge clk);
        cpl_valid = 1'b0; cpl_eop = 1'b0;
    endtask

    task automatic t_reset;
        check("R11 reset done", {31'd0, done}, 0);
        check("R5 reset busy", {31'd0, busy}, 0);
        check("R5 reset launch", {31'd0, launch}, 0);
    endtask

    task automatic t_hidden_bar;
        root_bus = 8'd0; prim_bus = 8'd0; link_lts = 4'h0;
        issue(1'b0, 8'd0, 8'd0, 12'h010, 2'd2);
        check("R1 done", {31'd0, done}, 1);
        check("R1 result", {30'd0, result}, 2);
        check("R1 no launch", {31'd0, launch}, 0);
        check("R1 rdata", rdata, 0);
        issue(1'b0, 8'd0, 8'd0, 12'h014, 2'd2);
        check("R1 neighbour launches", {31'd0, launch}, 1);
        beat(1'b1, 32'h1234_5678);
        check("R9 dword", rdata, 32'h1234_5678);
    endtask

    task automatic t_link;
        root_bus = 8'd0; prim_bus = 8'd9; link_lts = 4'h0;
        issue(1'b0, 8'd3, 8'd0, 12'h000, 2'd2);
        check("R2 down result", {30'd0, result}, 1);
        check("R2 down no launch", {31'd0, launch}, 0);
        check("R4 read ones", rdata, 32'hFFFF_FFFF);
        issue(1'b1, 8'd3, 8'd0, 12'h004, 2'd2);
        check("R4 write zero", rdata, 0);
        link_lts = 4'h8;
        issue(1'b0, 8'd3, 8'd0, 12'h000, 2'd2);
        check("R2 up launches", {31'd0, launch}, 1);
        beat(1'b1, 32'hCAFE_0001);
        check("R2 up result", {30'd0, result}, 0);
    endtask

    task automatic t_topology;
        root_bus = 8'd0; link_lts = 4'h1; prim_bus = 8'd5;
        issue(1'b0, 8'd0, 8'h08, 12'h000, 2'd2);
        check("R3 root dev1", {30'd0, result}, 1);
        check("R3 root dev1 launch", {31'd0, launch}, 0);
        prim_bus = 8'd0;
        issue(1'b0, 8'd1, 8'h10, 12'h000, 2'd2);
        check("R3 child dev2", {30'd0, result}, 1);
        issue(1'b0, 8'd1, 8'h07, 12'h000, 2'd2);
        check("R3 child fn7 ok", {31'd0, launch}, 1);
        beat(1'b1, 32'h0);
    endtask

    task automatic t_lanes;
        root_bus = 8'd0; prim_bus = 8'd0; link_lts = 4'h1;
        issue(1'b0, 8'd0, 8'd0, 12'h003, 2'd0);
        beat(1'b0, 32'h1111_1111);
        check("R5 no end", {31'd0, done}, 0);
        check("R5 still busy", {31'd0, busy}, 1);
        beat(1'b1, 32'hA1B2_C3D4);
        check("R7 byte3", rdata, 32'h0000_00A1);
        check("R5 ok", {30'd0, result}, 0);
        issue(1'b0, 8'd0, 8'd0, 12'h002, 2'd1);
        beat(1'b1, 32'hA1B2_C3D4);
        check("R8 half2", rdata, 32'h0000_A1B2);
        issue(1'b0, 8'd0, 8'd0, 12'h001, 2'd0);
        beat(1'b1, 32'hA1B2_C3D4);
        check("R7 byte1", rdata, 32'h0000_00C3);
        issue(1'b0, 8'd0, 8'd0, 12'h024, 2'd3);
        beat(1'b1, 32'hDEAD_BEEF);
        check("R9 dword size3", rdata, 32'hDEAD_BEEF);
    endtask

    task automatic t_idle_busy;
        root_bus = 8'd0; prim_bus = 8'd0; link_lts = 4'h1;
        @(negedge clk);
        beat(1'b1, 32'h5555_5555);
        check("R11 idle beat dropped", {31'd0, done}, 0);
        issue(1'b1, 8'd0, 8'd0, 12'h008, 2'd2);
        check("R10 write launches", {31'd0, launch}, 1);
        issue(1'b0, 8'd0, 8'd0, 12'h010, 2'd2);
        check("R11 busy req ignored", {31'd0, done}, 0);
        beat(1'b1, 32'h7777_7777);
        check("R10 write ok", {30'd0, result}, 0);
        check("R10 write rdata", rdata, 0);
        @(negedge clk);
        check("R11 single pulse", {31'd0, done}, 0);
    endtask

    // Measure cycles from launch to done with no end beat.
    task automatic wait_timeout(input string tag);
        int n = 0;
        while (!done && n < TMO + 10) begin
            @(negedge clk);
            n++;
        end
        check({tag, " cycles"}, n, TMO);
        check({tag, " result"}, {30'd0, result}, 3);
    endtask

    task automatic t_timeout;
        root_bus = 8'd0; prim_bus = 8'd0; link_lts = 4'h1;
        issue(1'b0, 8'd0, 8'd0, 12'h000, 2'd2);
        repeat (7) @(negedge clk);
        beat(1'b1, 32'h1);
        issue(1'b0, 8'd0, 8'd0, 12'h000, 2'd2);
        wait_timeout("R6 first");
        issue(1'b1, 8'd0, 8'd0, 12'h004, 2'd2);
        wait_timeout("R10 write");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hidden_bar();
        t_link();
        t_topology();
        t_lanes();
        t_idle_busy();
        t_timeout();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule